// File: doc/BRIEF.md
# Machine Security Configuration Register

This block keeps the three control bits that tighten memory protection for the most privileged execution level. The first, `lockdown`, switches protection rules into a strict mode in which machine code is bound by rules as well. The second, `deny_unmatched`, refuses machine accesses that match no rule. The third, `rule_unlock`, lets software edit locked rules, for example during boot.

Software writes the register through a simple write port. The block also sees the lock bit of every protection entry. It uses that vector to decide whether the unlock bit may still be raised. The first two bits can be set but never cleared. The unlock bit can no longer leave zero once it is zero and any implemented entry is locked.

Every accepted write raises a one-cycle pulse that tells the address-translation cache to flush. If the design is built with no protection entries, the register ignores all writes. The entries themselves and the access checks sit outside this block.

Top module: `sec_config_reg`

## Requirements
- R1: After synchronous reset, all three bits, `rd_data_o` and `flush_o` are zero.
- R2: `lockdown_o` (bit 0 of the write data and of `rd_data_o`) is set by an accepted write with bit 0 high. Once set, it stays high until reset, whatever is written later.
- R3: `deny_unmatched_o` (bit 1) is set by an accepted write with bit 1 high. Once set, it stays high until reset, whatever is written later.
- R4: `rule_unlock_o` (bit 2) takes written bit 2 on an accepted write when it is currently 1, or when no implemented entry lock is set.
- R5: When `rule_unlock_o` is 0 and at least one implemented entry lock bit is high, an accepted write leaves it at 0.
- R6: Every implemented entry (lock index below `NUM_ENTRIES`) counts toward R5, whatever its address mode. Lock inputs at or above `NUM_ENTRIES` are ignored.
- R7: `flush_o` is high for exactly the one cycle after each accepted write, even when the value does not change. It is low in every other cycle.
- R8: With `NUM_ENTRIES` = 0, writes are not accepted: the value stays unchanged and `flush_o` stays low.
- R9: `rd_data_o` carries lockdown in bit 0, deny_unmatched in bit 1 and rule_unlock in bit 2. All other bits read zero, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Write data |
| entry_lock_i | input | MAX_ENTRIES | Lock bit of each protection entry |
| lockdown_o | output | 1 | Strict rule mode bit |
| deny_unmatched_o | output | 1 | Deny machine accesses that match no rule |
| rule_unlock_o | output | 1 | Locked-rule edit bypass |
| rd_data_o | output | DATA_W | Register read value |
| flush_o | output | 1 | Translation-cache flush pulse |

## Verification
The unlock freeze and the write that tries to raise the bit can meet in one cycle. The bench holds an implemented lock bit high while writing a 1 to bit 2, and expects the bit to stay at 0 while the flush pulse still fires. The same cycle is also driven with the bit already at 1, and with only an unimplemented lock high. Both of those cases must take the written value. Sticky set and attempted clear likewise share a write: writing zeros after a set must flush yet leave bits 0 and 1 high.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam int LOCKDOWN_BIT = 0;
  localparam int DENY_BIT     = 1;
  localparam int UNLOCK_BIT   = 2;
  localparam int FIELD_W      = 3;

  typedef struct packed {
    logic unlock;
    logic deny_unmatched;
    logic lockdown;
  } secreg_t;
endpackage

// File: rtl/secreg_lock_scan.sv
module secreg_lock_scan #(
  parameter int MAX_ENTRIES = 16,
  parameter int NUM_ENTRIES = 8
) (
  input  logic [MAX_ENTRIES-1:0] lock_i,
  output logic                   any_lock_o
);
  localparam int IMPL = (NUM_ENTRIES > MAX_ENTRIES) ? MAX_ENTRIES : NUM_ENTRIES;

  logic [MAX_ENTRIES-1:0] masked;

  for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_mask
    if (g < IMPL) begin : g_impl
      assign masked[g] = lock_i[g];
    end else begin : g_absent
      assign masked[g] = 1'b0;
    end
  end

  assign any_lock_o = |masked;
endmodule

// File: rtl/secreg_next.sv
module secreg_next
  import secreg_pkg::*;
(
  input  secreg_t              cur_i,
  input  logic [FIELD_W-1:0]   wbits_i,
  input  logic                 any_lock_i,
  output secreg_t              nxt_o
);
  logic unlock_frozen;

  always_comb begin
    unlock_frozen             = any_lock_i && !cur_i.unlock;
    nxt_o.lockdown            = cur_i.lockdown | wbits_i[LOCKDOWN_BIT];
    nxt_o.deny_unmatched      = cur_i.deny_unmatched | wbits_i[DENY_BIT];
    nxt_o.unlock              = unlock_frozen ? 1'b0 : wbits_i[UNLOCK_BIT];
  end
endmodule

// File: rtl/sec_config_reg.sv
module sec_config_reg
  import secreg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int MAX_ENTRIES = 16,
  parameter int NUM_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [MAX_ENTRIES-1:0] entry_lock_i,
  output logic                   lockdown_o,
  output logic                   deny_unmatched_o,
  output logic                   rule_unlock_o,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   flush_o
);
  localparam bit HAS_ENTRIES = (NUM_ENTRIES > 0);

  secreg_t cfg_q;
  secreg_t cfg_nxt;
  logic    any_lock;
  logic    wr_accept;

  assign wr_accept = wr_en_i && HAS_ENTRIES;

  secreg_lock_scan #(
    .MAX_ENTRIES(MAX_ENTRIES),
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_scan (
    .lock_i    (entry_lock_i),
    .any_lock_o(any_lock)
  );

  secreg_next u_next (
    .cur_i     (cfg_q),
    .wbits_i   (wr_data_i[FIELD_W-1:0]),
    .any_lock_i(any_lock),
    .nxt_o     (cfg_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      flush_o <= 1'b0;
    end else begin
      flush_o <= wr_accept;
      if (wr_accept) cfg_q <= cfg_nxt;
    end
  end

  assign lockdown_o       = cfg_q.lockdown;
  assign deny_unmatched_o = cfg_q.deny_unmatched;
  assign rule_unlock_o    = cfg_q.unlock;

  always_comb begin
    rd_data_o               = '0;
    rd_data_o[LOCKDOWN_BIT] = cfg_q.lockdown;
    rd_data_o[DENY_BIT]     = cfg_q.deny_unmatched;
    rd_data_o[UNLOCK_BIT]   = cfg_q.unlock;
  end

  // R2
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lockdown_o |=> lockdown_o);

  // R3
  deny_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    deny_unmatched_o |=> deny_unmatched_o);

  // R5
  unlock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!rule_unlock_o && any_lock) |=> !rule_unlock_o);

  // R7
  flush_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> flush_o);

  // R7
  flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> !flush_o);

  // R8
  no_entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!HAS_ENTRIES && wr_en_i) |=> ($stable(rd_data_o) && !flush_o));
endmodule

// File: tb/sim_sec_config_reg.sv
`timescale 1ns/1ps
module sim_sec_config_reg;
  localparam int DW = 32;
  localparam int ME = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [ME-1:0] locks = '0;
  logic          z_wr_en = 1'b0;

  logic          lockdown, deny, unlock, flush;
  logic [DW-1:0] rd_data;
  logic          z_lockdown, z_deny, z_unlock, z_flush;
  logic [DW-1:0] z_rd_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sec_config_reg #(.DATA_W(DW), .MAX_ENTRIES(ME), .NUM_ENTRIES(8)) u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .entry_lock_i(locks), .lockdown_o(lockdown), .deny_unmatched_o(deny),
    .rule_unlock_o(unlock), .rd_data_o(rd_data), .flush_o(flush)
  );

  sec_config_reg #(.DATA_W(DW), .MAX_ENTRIES(ME), .NUM_ENTRIES(0)) u_zero (
    .clk(clk), .rst(rst), .wr_en_i(z_wr_en), .wr_data_i(wr_data),
    .entry_lock_i(locks), .lockdown_o(z_lockdown), .deny_unmatched_o(z_deny),
    .rule_unlock_o(z_unlock), .rd_data_o(z_rd_data), .flush_o(z_flush)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; z_wr_en = 1'b0; locks = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // write at one edge; on return the value and flush pulse are visible
  task automatic do_write(logic [DW-1:0] d, logic [ME-1:0] lk);
    @(negedge clk);
    wr_data = d; locks = lk; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rd_data", rd_data, 0);
    check("R1 bits", {29'd0, unlock, deny, lockdown}, 0);
    check("R1 flush", {31'd0, flush}, 0);
  endtask

  task automatic t_sticky();
    do_reset();
    do_write(32'h3, '0);
    check("R2 lockdown set", {31'd0, lockdown}, 1);
    check("R3 deny set", {31'd0, deny}, 1);
    check("R7 flush after write", {31'd0, flush}, 1);
    @(negedge clk);
    check("R7 flush single cycle", {31'd0, flush}, 0);
    do_write(32'h0, '0);
    check("R2 R3 clear ignored", rd_data, 32'h3);
    check("R7 flush on unchanged value", {31'd0, flush}, 1);
  endtask

  task automatic t_unlock_follow();
    do_reset();
    do_write(32'h4, '0);
    check("R4 unlock set", rd_data, 32'h4);
    do_write(32'h4, 16'h0008);
    check("R4 unlock held at 1 with lock", {31'd0, unlock}, 1);
    do_write(32'h0, 16'h0008);
    check("R4 unlock cleared with lock", {31'd0, unlock}, 0);
  endtask

  task automatic t_unlock_freeze();
    do_reset();
    do_write(32'h4, 16'h0080);
    check("R5 R6 frozen by top entry", {31'd0, unlock}, 0);
    check("R7 flush while frozen", {31'd0, flush}, 1);
    do_write(32'h4, 16'h0001);
    check("R5 R6 frozen by entry 0", {31'd0, unlock}, 0);
  endtask

  task automatic t_unimpl_lock();
    do_reset();
    do_write(32'h4, 16'hFF00);
    check("R6 unimplemented locks ignored", {31'd0, unlock}, 1);
  endtask

  task automatic t_layout();
    do_reset();
    do_write(32'hFFFF_FFFA, '0);
    check("R9 upper bits read zero", rd_data, 32'h2);
    check("R9 bit1 is deny", {30'd0, deny, lockdown}, 32'h2);
  endtask

  task automatic t_idle();
    do_reset();
    @(negedge clk);
    wr_data = 32'h7;
    @(negedge clk);
    check("R7 no flush without write", {31'd0, flush}, 0);
    check("R7 value unchanged without write", rd_data, 0);
  endtask

  task automatic t_zero_entries();
    do_reset();
    @(negedge clk);
    wr_data = 32'h7; z_wr_en = 1'b1;
    @(negedge clk);
    z_wr_en = 1'b0;
    check("R8 value unchanged", z_rd_data, 0);
    check("R8 no flush", {31'd0, z_flush}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sticky();
    t_unlock_follow();
    t_unlock_freeze();
    t_unimpl_lock();
    t_layout();
    t_idle();
    t_zero_entries();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule